// File: doc/BRIEF.md
# Serial Hamming (8,4) Decoder

The block takes in an eight-bit Hamming code word one bit per clock, lowest position first, with each bit qualified by a valid input. Gaps in the valid input stretch the word without breaking it. Once the eighth bit has been taken in, the block forms a four-bit syndrome. The syndrome has three check sums over subsets of the word and one overall parity sum. From it the block recovers the four data bits, which sit on the odd positions.

Any single flipped bit is repaired. A flip on a parity position leaves the data as received. A flip on a data position inverts that data bit. If the overall parity is intact but a check sum fails, two bits have been flipped. That word cannot be repaired, so it is reported as uncorrectable and is not marked valid. The result appears as a one-cycle strobe, together with a flag that says whether a repair was made.

Top module: `hd_decoder`

## Requirements
- R1: While rst_ni is low and in the first cycle after it is released, valid_o, corrected_o and uncorr_o are 0 and data_o is 4'h0.
- R2: A bit on bit_i is taken only in a cycle with valid_i high. The first such bit is position 0 and the eighth is position 7. Cycles with valid_i low leave the partial word and the position count untouched.
- R3: The check sums are A = c0^c1^c5^c7, B = c1^c2^c3^c7 and C = c1^c3^c4^c5. D is the XOR of all eight bits. A clean word has A=B=C=D=1. For a clean word, valid_o is 1, corrected_o is 0 and data_o = {c7, c5, c3, c1}.
- R4: If D=0 and the failing checks point at a data position, that data bit is inverted. All three checks failing points at c1, B and C at c3, A and C at c5, and A and B at c7. The word is reported with valid_o=1 and corrected_o=1.
- R5: If D=0 and the failing checks point at a parity position (c0, c2, c4 or c6), data_o carries the received data bits unchanged, with valid_o=1 and corrected_o=1.
- R6: If D=1 and any of A, B or C is 0, uncorr_o is 1 while valid_o and corrected_o are 0, and data_o keeps its previous value.
- R7: The valid_o or uncorr_o strobe is high for exactly the one cycle after the clock edge that takes the eighth bit.
- R8: Outside a strobe, data_o holds the last value delivered with valid_o.
- R9: A new word may begin in the cycle directly after the eighth bit of the previous word, with no idle cycle between them, and both words are decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | bit_i carries a code bit this cycle |
| bit_i | input | 1 | Serial code bit, position 0 first |
| data_o | output | 4 | Decoded data word |
| valid_o | output | 1 | One-cycle strobe: data_o holds a good word |
| corrected_o | output | 1 | A single flipped bit was repaired in this word |
| uncorr_o | output | 1 | One-cycle strobe: the word had an uncorrectable error |

## Verification
Internal state that is wrong mostly shows up in when the strobes fire. A position counter that drifts, or that counts idle cycles, moves the strobe off the eighth valid bit. It also hands the syndrome logic a rotated word, so clean words come out flagged as corrected or as uncorrectable, and this shows on the first word decoded. A wrong correction mask shows as a wrong data_o, in the same strobe cycle as the faulty word. Sending every single flip and every double flip through the block tests each syndrome pattern at the ports.

// File: rtl/hd_pkg.sv
`timescale 1ns/1ps
package hd_pkg;
  localparam int unsigned CW = 8;
  localparam int unsigned DW = 4;

  // 1 = check passes
  typedef struct packed {
    logic a;
    logic b;
    logic c;
    logic d;
  } syn_t;

  typedef enum logic [1:0] {
    VD_CLEAN = 2'd0,
    VD_FIXED = 2'd1,
    VD_FAIL  = 2'd2
  } verdict_t;
endpackage

// File: rtl/hd_deser.sv
`timescale 1ns/1ps
module hd_deser #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          bit_i,
  output logic [CW-1:0] word_o,
  output logic          done_o
);
  localparam int unsigned CNT_W = $clog2(CW);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CW - 1);

  logic [CW-2:0]    sh_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (valid_i) begin
      sh_q  <= {bit_i, sh_q[CW-2:1]};
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  // full word is visible while the last bit is on the wire
  assign word_o = {bit_i, sh_q};
  assign done_o = valid_i && (cnt_q == LAST);
endmodule

// File: rtl/hd_syndrome.sv
`timescale 1ns/1ps
module hd_syndrome
  import hd_pkg::*;
(
  input  logic [CW-1:0] word_i,
  output syn_t          syn_o
);
  always_comb begin
    syn_o.a = word_i[0] ^ word_i[1] ^ word_i[5] ^ word_i[7];
    syn_o.b = word_i[1] ^ word_i[2] ^ word_i[3] ^ word_i[7];
    syn_o.c = word_i[1] ^ word_i[3] ^ word_i[4] ^ word_i[5];
    syn_o.d = ^word_i;
  end
endmodule

// File: rtl/hd_correct.sv
`timescale 1ns/1ps
module hd_correct
  import hd_pkg::*;
(
  input  logic [CW-1:0] word_i,
  input  syn_t          syn_i,
  output logic [DW-1:0] data_o,
  output verdict_t      verdict_o
);
  logic [DW-1:0] raw;
  logic [DW-1:0] flip;

  for (genvar g = 0; g < DW; g++) begin : g_pick
    assign raw[g] = word_i[2*g+1];
  end

  always_comb begin
    flip = '0;
    if (!syn_i.d) begin
      unique case ({syn_i.a, syn_i.b, syn_i.c})
        3'b000:  flip = 4'b0001;
        3'b100:  flip = 4'b0010;
        3'b010:  flip = 4'b0100;
        3'b001:  flip = 4'b1000;
        default: flip = '0;
      endcase
    end
  end

  always_comb begin
    if (!syn_i.d)                           verdict_o = VD_FIXED;
    else if (syn_i.a && syn_i.b && syn_i.c) verdict_o = VD_CLEAN;
    else                                    verdict_o = VD_FAIL;
  end

  assign data_o = raw ^ flip;
endmodule

// File: rtl/hd_decoder.sv
`timescale 1ns/1ps
module hd_decoder
  import hd_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          bit_i,
  output logic [DW-1:0] data_o,
  output logic          valid_o,
  output logic          corrected_o,
  output logic          uncorr_o
);
  logic [CW-1:0] word;
  logic          done;
  syn_t          syn;
  logic [DW-1:0] fixed_data;
  verdict_t      verdict;

  hd_deser #(.CW(CW)) u_deser (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .bit_i  (bit_i),
    .word_o (word),
    .done_o (done)
  );

  hd_syndrome u_syn (
    .word_i(word),
    .syn_o (syn)
  );

  hd_correct u_cor (
    .word_i   (word),
    .syn_i    (syn),
    .data_o   (fixed_data),
    .verdict_o(verdict)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o      <= '0;
      valid_o     <= 1'b0;
      corrected_o <= 1'b0;
      uncorr_o    <= 1'b0;
    end else begin
      valid_o     <= done && (verdict != VD_FAIL);
      corrected_o <= done && (verdict == VD_FIXED);
      uncorr_o    <= done && (verdict == VD_FAIL);
      if (done && verdict != VD_FAIL) data_o <= fixed_data;
    end
  end
endmodule

// File: rtl/hd_decoder_chk.sv
`timescale 1ns/1ps
module hd_decoder_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       valid_i,
  input logic [3:0] data_o,
  input logic       valid_o,
  input logic       corrected_o,
  input logic       uncorr_o
);
  // R6
  excl_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && uncorr_o));

  // R4
  fix_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    corrected_o |-> valid_o);

  // R7
  one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o || uncorr_o) |=> !(valid_o || uncorr_o));

  // R2
  strobe_after_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o || uncorr_o) |-> $past(valid_i));

  // R8
  hold_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(data_o));
endmodule

bind hd_decoder hd_decoder_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .data_o     (data_o),
  .valid_o    (valid_o),
  .corrected_o(corrected_o),
  .uncorr_o   (uncorr_o)
);

// File: tb/sim_hd_decoder.sv
`timescale 1ns/1ps
module sim_hd_decoder;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic       bit_i = 1'b0;
  logic [3:0] data_o;
  logic       valid_o, corrected_o, uncorr_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [3:0] last_good = 4'h0;

  always #2 clk_i = ~clk_i;

  hd_decoder u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .bit_i(bit_i),
    .data_o(data_o), .valid_o(valid_o), .corrected_o(corrected_o), .uncorr_o(uncorr_o)
  );

  always @(posedge clk_i) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, act=%0d cycles exp<150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [7:0] encode(input logic [3:0] d);
    logic [7:0] c;
    c = '0;
    c[1] = d[0]; c[3] = d[1]; c[5] = d[2]; c[7] = d[3];
    c[0] = ~(c[1] ^ c[5] ^ c[7]);
    c[2] = ~(c[1] ^ c[3] ^ c[7]);
    c[4] = ~(c[1] ^ c[3] ^ c[5]);
    c[6] = ~(c[0] ^ c[1] ^ c[2] ^ c[3] ^ c[4] ^ c[5] ^ c[7]);
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // drives 8 bits, optional idle gap after bit 3, leaves valid_i low
  task automatic send(input logic [7:0] c, input bit gap);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i);
      valid_i = 1'b1;
      bit_i = c[i];
      if (gap && i == 4) begin
        valid_i = 1'b0;
        bit_i = ~c[i];
        @(negedge clk_i);
        @(negedge clk_i);
        valid_i = 1'b1;
        bit_i = c[i];
      end
    end
    @(negedge clk_i);
    valid_i = 1'b0;
    bit_i = 1'b0;
  endtask

  task automatic expect_good(input string req, input logic [3:0] d, input bit fixed);
    check(valid_o === 1'b1, req, valid_o, 1);
    check(uncorr_o === 1'b0, req, uncorr_o, 0);
    check(corrected_o === fixed, req, corrected_o, fixed);
    check(data_o === d, req, data_o, d);
    last_good = d;
  endtask

  task automatic test_reset();
    check(valid_o === 1'b0 && corrected_o === 1'b0 && uncorr_o === 1'b0, "R1 flags", {valid_o, corrected_o, uncorr_o}, 0);
    check(data_o === 4'h0, "R1 data", data_o, 0);
  endtask

  task automatic test_clean();
    for (int d = 0; d < 16; d++) begin
      send(encode(4'(d)), 1'b0);
      expect_good("R3 clean", 4'(d), 1'b0);
      @(negedge clk_i);
      check(valid_o === 1'b0 && uncorr_o === 1'b0, "R7 pulse width", valid_o, 0);
      check(data_o === 4'(d), "R8 hold", data_o, d);
    end
  endtask

  task automatic test_single();
    for (int d = 0; d < 16; d += 5) begin
      for (int p = 0; p < 8; p++) begin
        logic [7:0] c;
        c = encode(4'(d));
        c[p] = ~c[p];
        send(c, 1'b0);
        if (p % 2 == 1) expect_good("R4 data-bit flip", 4'(d), 1'b1);
        else            expect_good("R5 parity-bit flip", 4'(d), 1'b1);
      end
    end
  endtask

  task automatic test_double();
    for (int p = 0; p < 8; p++) begin
      for (int q = p + 1; q < 8; q++) begin
        logic [7:0] c;
        c = encode(4'hA);
        c[p] = ~c[p];
        c[q] = ~c[q];
        send(c, 1'b0);
        check(uncorr_o === 1'b1, "R6 flag", uncorr_o, 1);
        check(valid_o === 1'b0 && corrected_o === 1'b0, "R6 not valid", {valid_o, corrected_o}, 0);
        check(data_o === last_good, "R6 data held", data_o, last_good);
        @(negedge clk_i);
        check(uncorr_o === 1'b0, "R7 uncorr width", uncorr_o, 0);
      end
    end
  endtask

  task automatic test_gap();
    logic [7:0] c;
    c = encode(4'h6);
    send(c, 1'b1);
    expect_good("R2 gap", 4'h6, 1'b0);
    c = encode(4'h9);
    c[3] = ~c[3];
    send(c, 1'b1);
    expect_good("R2 gap+fix", 4'h9, 1'b1);
  endtask

  task automatic test_back_to_back();
    logic [7:0] c0, c1;
    c0 = encode(4'h3);
    c1 = encode(4'hC);
    c1[7] = ~c1[7];
    for (int i = 0; i < 16; i++) begin
      @(negedge clk_i);
      if (i == 8) expect_good("R9 first word", 4'h3, 1'b0);
      else if (i > 0 && i < 8)
        check(valid_o === 1'b0 && uncorr_o === 1'b0, "R7 no early strobe", valid_o, 0);
      valid_i = 1'b1;
      bit_i = (i < 8) ? c0[i] : c1[i-8];
    end
    @(negedge clk_i);
    valid_i = 1'b0;
    expect_good("R9 second word", 4'hC, 1'b1);
  endtask

  initial begin
    #1;
    test_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    test_reset();
    test_clean();
    test_single();
    test_double();
    test_gap();
    test_back_to_back();
    repeat (3) @(negedge clk_i);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule